// File: doc/BRIEF.md
# Modulo PWM Timer Channel

This block is a free-running up-counter with a programmable wrap value, a power-of-two clock divider and one compare channel. Together they produce an edge-aligned pulse-width-modulated output. Each period begins when the counter wraps to zero. At that point the output takes its active level. It returns to the inactive level when the counter reaches the compare value. The pulse therefore lasts as many counter ticks as the compare value holds. A single write port loads the wrap value, the compare value, the divider code, the output polarity and two interrupt enables, and it clears the two event flags.

The compare register has no shadow copy. A new value is used from the cycle after the write. If software writes a value the counter has already passed, the end-of-pulse match is missed for that period. The output then stays active until the next wrap, which restores normal operation. Because the output is driven by set-on-wrap and clear-on-match rather than by a toggle, a 0% duty cycle can be reached and a missed match cannot invert the waveform.

Top module: `modulo_pwm_timer`

## Requirements
- R1: After reset the output is low and both flags and both interrupt requests are low. The wrap value resets to all ones, the compare value to 0, and all configuration fields to 0.
- R2: The counter steps 0, 1, ..., M and then returns to 0, where M is the wrap value written at address 0. One period is (M+1) counter ticks. The wrap flag (flag bit 0) rises on the clock edge that returns the counter to 0.
- R3: The divider code is configuration bits [2:0] at address 2. Code k in 0..6 makes one counter tick every 2^k clocks. Code 7 behaves as code 6, which is 64 clocks.
- R4: With compare value C written at address 1, the pulse is active for the first min(C, M+1) ticks of each period. C = 0 gives 0% duty and C > M gives 100% duty.
- R5: Configuration bit 3 selects the polarity. 0 makes the active level high and 1 makes it low.
- R6: A compare write takes effect on the next clock. A value below the current count means no match occurs in that period, so the output stays active until the wrap. The following period has the new width.
- R7: The match flag (flag bit 1) sets when the counter reaches C. It never sets when C > M.
- R8: Writing 1 to a bit at address 3 clears that flag. A flag whose event occurs in the same cycle as the clear stays set.
- R9: The wrap interrupt request equals the wrap flag gated by configuration bit 4. The match interrupt request equals the match flag gated by configuration bit 5.
- R10: A write to address 0 restarts the counter and the divider at 0 and places the output at its period-start level. No wrap or match event is produced in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 wrap value, 1 compare, 2 configuration, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM waveform |
| ovf_flag | output | 1 | End-of-period flag |
| cmp_flag | output | 1 | End-of-pulse flag |
| ovf_irq | output | 1 | Wrap interrupt request |
| cmp_irq | output | 1 | Match interrupt request |

## Verification
The main function is swept over every wrap value 0..7, every compare value 0..9 and divider codes 0, 1, 2 and 7, with the polarity alternating. For each combination one period is measured after a restart. The count of active cycles and the index of the first inactive cycle separate correct width from a stretched or shifted pulse. The compare values at and above M+1 separate 100% duty from an off-by-one match. Code 7 separates the clamp from an eight-bit divide. A directed run writes a smaller compare value after the counter has passed it, which exposes a missed match and the recovery in the next period. A one-tick period keeps the wrap flag re-arming every cycle, so the set-over-clear priority and the interrupt gating can be observed directly.

// File: rtl/pwm_timer_pkg.sv
// Package: shared register addresses and configuration layout for the
// modulo PWM timer. Assumes the write data bus is at least 6 bits wide.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        REG_MODULO  = 2'd0,
        REG_COMPARE = 2'd1,
        REG_CONFIG  = 2'd2,
        REG_FLAGS   = 2'd3
    } reg_sel_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_CMP  = 1;
    localparam int CFG_W     = 6;

    typedef struct packed {
        logic       cmp_ie;   // bit 5
        logic       ovf_ie;   // bit 4
        logic       pol_low;  // bit 3
        logic [2:0] presc;    // bits 2:0
    } cfg_t;

endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Produces a one-clock tick every 2^k clocks, where k is the select code
// clamped to DIV_W. A restart returns the divider to phase 0.
// Assumes DIV_W <= 7 so the clamp fits the 3-bit select.
module pwm_prescaler #(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       restart,
    output logic       tick
);
    localparam logic [2:0] MAX_SEL = 3'(DIV_W);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [2:0]       eff_sel;

    // Clamp the select code and build the low-bit mask for the divide ratio.
    always_comb begin
        eff_sel = (sel > MAX_SEL) ? MAX_SEL : sel;
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(eff_sel));
        end
        tick = ((div_q & mask) == mask);
    end

    // Free-running divider, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R3: with a divide ratio above one, two ticks never fall on adjacent clocks.
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 3'd0) |=> (!tick || sel == 3'd0));

endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Up-counter that wraps from the modulo value to zero on a tick. It reports
// the wrap event and the value the counter takes on the next tick. A restart
// forces zero and suppresses the event. Assumes restart coincides with the
// modulo register update.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] next_cnt,
    output logic             ovf_ev
);
    logic at_top;

    // Decide the wrap and the next count value.
    always_comb begin
        at_top   = (cnt >= modulo);
        next_cnt = at_top ? '0 : cnt + 1'b1;
        ovf_ev   = tick && !restart && at_top;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= next_cnt;
        end
    end

    // R2: the count never exceeds the modulo value.
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= modulo);
    // R2: a wrap event leaves the counter at zero.
    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> cnt == '0);
    // R10: a restart leaves the counter at zero.
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == '0);

endmodule

// File: rtl/pwm_out_stage.sv
// Module: pwm_out_stage
// Holds the pulse state. It is set at period start and cleared when the count
// reaches the live compare value. It also flags the match. The compare value
// is used unbuffered, so a value already passed is never matched that period.
module pwm_out_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             ovf_ev,
    input  logic [CNT_W-1:0] next_cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             cmp_ev,
    output logic             active
);
    // Detect a match on the count being entered.
    always_comb begin
        cmp_ev = tick && !restart && (next_cnt == cmp);
    end

    // Pulse state: period start sets it (unless the width is zero), match clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (restart || ovf_ev) begin
            active <= (cmp != '0);
        end else if (cmp_ev) begin
            active <= 1'b0;
        end
    end

    // R4: a zero compare keeps the pulse off from the period start.
    p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ev && cmp == '0) |=> !active);
    // R4: a nonzero compare turns the pulse on at the period start.
    p_period_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_ev || restart) && cmp != '0) |=> active);
    // R6: the pulse can only start at a wrap or restart, never mid-period.
    p_no_mid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_ev && !restart) |=> !$rose(active));

endmodule

// File: rtl/pwm_flags.sv
// Module: pwm_flags
// A bank of sticky event flags, cleared by writing ones. A set in the same
// cycle as a clear wins.
module pwm_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky flag with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag[g] <= 1'b0;
            end else if (set_ev[g]) begin
                flag[g] <= 1'b1;
            end else if (clr[g]) begin
                flag[g] <= 1'b0;
            end
        end

        // R8: an event always leaves the flag set, even against a clear.
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[g] |=> flag[g]);
        // R8: a clear without an event drops the flag.
        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !set_ev[g]) |=> !flag[g]);
    end

endmodule

// File: rtl/modulo_pwm_timer.sv
// Module: modulo_pwm_timer
// Top of the modulo PWM timer: register write port, divider, counter,
// output stage and flags. Assumes CNT_W >= 6 so the configuration fits the
// write bus, and DIV_W <= 7.
module modulo_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             ovf_irq,
    output logic             cmp_irq
);
    logic [CNT_W-1:0]     mod_q;
    logic [CNT_W-1:0]     cmp_q;
    cfg_t                 cfg_q;
    logic                 restart;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flags;
    logic                 tick;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     next_cnt;
    logic                 ovf_ev;
    logic                 cmp_ev;
    logic                 active;

    // Decode the write port into restart and flag-clear strobes.
    always_comb begin
        restart  = wr_en && (reg_sel_e'(wr_addr) == REG_MODULO);
        flag_clr = (wr_en && reg_sel_e'(wr_addr) == REG_FLAGS)
                   ? wr_data[NUM_FLAGS-1:0] : '0;
    end

    // Programmable registers; the compare value is live with no shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '1;
            cmp_q <= '0;
            cfg_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_MODULO:  mod_q <= wr_data;
                REG_COMPARE: cmp_q <= wr_data;
                REG_CONFIG:  cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
                default:     ;
            endcase
        end
    end

    pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cfg_q.presc),
        .restart (restart),
        .tick    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .modulo   (mod_q),
        .cnt      (cnt),
        .next_cnt (next_cnt),
        .ovf_ev   (ovf_ev)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .ovf_ev   (ovf_ev),
        .next_cnt (next_cnt),
        .cmp      (cmp_q),
        .cmp_ev   (cmp_ev),
        .active   (active)
    );

    // Route the events into the flag bank.
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_OVF] = ovf_ev;
        flag_set[FLAG_CMP] = cmp_ev;
    end

    pwm_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (flag_set),
        .clr    (flag_clr),
        .flag   (flags)
    );

    // Drive the pin, flags and interrupt requests.
    always_comb begin
        pwm_out  = active ^ cfg_q.pol_low;
        ovf_flag = flags[FLAG_OVF];
        cmp_flag = flags[FLAG_CMP];
        ovf_irq  = ovf_flag && cfg_q.ovf_ie;
        cmp_irq  = cmp_flag && cfg_q.cmp_ie;
    end

    // R10: the restart cycle produces no event, so flags cannot rise on it.
    p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !ovf_flag) |=> !$rose(ovf_flag));

endmodule

// File: tb/modulo_pwm_timer_tb.sv
// Bench: sweeps wrap, compare and divider settings on an 8-bit counter,
// plus directed runs for the missed match and for flag handling.
module modulo_pwm_timer_tb;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_out, ovf_flag, cmp_flag, ovf_irq, cmp_irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    modulo_pwm_timer #(.CNT_W(CNT_W), .DIV_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One register write; called and returning at a falling edge.
    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // One period after a clean restart, with the measured values checked.
    task automatic run_combo(input int m, input int c, input int p, input int pol);
        int shift, n, wexp, hi, first_low;
        shift = (p > 6) ? 6 : p;
        n     = (m + 1) << shift;
        wexp  = ((c < m + 1) ? c : m + 1) << shift;
        wr(1, c);
        wr(2, (pol << 3) | 6);
        wr(0, 15);
        wr(3, 3);
        wr(2, (pol << 3) | p);
        wr(0, m);
        hi = 0;
        first_low = n;
        for (int i = 0; i < n; i++) begin
            if ((pwm_out ^ pol[0]) == 1'b1) hi++;
            else if (first_low == n) first_low = i;
            if (i == n - 1)
                chk(ovf_flag == 1'b0, "R2 wrap flag early", ovf_flag, 0);
            @(negedge clk);
        end
        chk(hi == wexp, "R4/R5 active cycles", hi, wexp);
        chk(first_low == ((wexp == n) ? n : wexp), "R4/R3 pulse end", first_low,
            (wexp == n) ? n : wexp);
        chk(ovf_flag == 1'b1, "R2/R10 wrap flag at period end", ovf_flag, 1);
        chk(cmp_flag == (c <= m), "R7 match flag", cmp_flag, int'(c <= m));
    endtask

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pwm_out == 0 && ovf_flag == 0 && cmp_flag == 0, "R1 outputs at reset",
            {pwm_out, ovf_flag, cmp_flag}, 0);
        chk(ovf_irq == 0 && cmp_irq == 0, "R1 irqs at reset", {ovf_irq, cmp_irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 0, "R1 output after release", pwm_out, 0);

        // Sweep for R2, R3, R4, R5, R7, R10.
        for (int pi = 0; pi < 4; pi++) begin
            for (int m = 0; m < 8; m++) begin
                for (int c = 0; c < 10; c++) begin
                    run_combo(m, c, (pi == 3) ? 7 : pi, (m + c) % 2);
                end
            end
        end

        // R6: missed match after writing a compare value below the count.
        wr(1, 10);
        wr(2, 0);
        wr(0, 15);
        wr(3, 3);
        hi = 0;
        for (int i = 0; i < 15; i++) begin
            if (pwm_out) hi++;
            if (i == 6) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd4;
            end
            @(negedge clk);
            if (i == 6) wr_en = 1'b0;
        end
        chk(hi == 15, "R6 missed match keeps pulse active", hi, 15);
        chk(cmp_flag == 0, "R6 no match flag in missed period", cmp_flag, 0);
        hi = 0;
        for (int i = 0; i < 16; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
        chk(hi == 4, "R6 recovered width next period", hi, 4);
        chk(cmp_flag == 1, "R6 match flag after recovery", cmp_flag, 1);

        // R8, R9: one-tick period keeps the wrap event firing every clock.
        wr(1, 1);
        wr(2, 0);
        wr(0, 0);
        repeat (2) @(negedge clk);
        chk(ovf_flag == 1, "R8 wrap flag set", ovf_flag, 1);
        chk(ovf_irq == 0, "R9 irq masked", ovf_irq, 0);
        chk(cmp_irq == 0, "R9 match irq masked", cmp_irq, 0);
        wr(3, 1);
        chk(ovf_flag == 1, "R8 set wins over clear", ovf_flag, 1);
        wr(2, 8'h10);
        chk(ovf_irq == 1, "R9 irq enabled", ovf_irq, 1);
        wr(2, 8'h36);
        wr(0, 15);
        wr(3, 3);
        chk(ovf_flag == 0 && cmp_flag == 0, "R8 clear by writing ones",
            {ovf_flag, cmp_flag}, 0);
        chk(ovf_irq == 0 && cmp_irq == 0, "R9 irq follows flag", {ovf_irq, cmp_irq}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule